// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management-bus master that carries out one Clause 22 read or write transaction towards an external PHY for each command it is given. Software sees two 32-bit registers behind a small register port: a command register and a data register. For a write, the 16-bit value goes into the data register first. The command word is then written with its start/busy bit set, and the controller serialises the whole frame on the MDC and MDIO pins. For a read, the PHY's reply is left in the data register once the busy bit drops back to zero.

The MDC clock is produced only while a transaction runs and idles low otherwise. A two-bit field in the command word picks the division of the system clock (16, 32, 64 or 128), so that the rate can be brought to about 2.5 MHz whatever the system clock is. MDIO is a split tristate pin: a driven value, an output enable and the line value read back. The master changes the line only while MDC is low and samples the PHY on the rising edge of MDC.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, both registers read as zero, MDC is low and the MDIO output enable is low. The output enable is also low whenever no transaction is running.
- R2: Writing the command register (address 0) with bit 0 set while idle starts a transaction. Bit 0 then reads back as 1 and clears by itself once the last MDC falling edge is done, 64 MDC periods after the start. A command write with bit 0 clear starts nothing.
- R3: The MDC period is 16 << S system cycles, where S is command bits 13:12, with equal high and low halves. MDC stays low between transactions.
- R4: A write frame (command bit 1 set) is 32 ones, then 01, opcode 01, the PHY address (command bits 11:7), the register address (command bits 6:2), turnaround 10 and the 16 data bits. Every field is sent MSB first, and the output enable is high for all 64 bits.
- R5: A read frame (command bit 1 clear) uses opcode 10. The master releases MDIO (output enable low) for the last 18 bit times. When busy clears, the data register holds the 16 bits sampled in the final 16 bit times, MSB first.
- R6: The MDIO output value and output enable change only while MDC is low.
- R7: While busy is set, command writes and data-register writes are ignored. The running frame keeps its fields, and the data register and command fields read back unchanged.
- R8: The command register reads back as the PHY address, register address, divider and write bit of the last accepted command, plus busy in bit 0. A write transaction leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the register selected in the previous cycle |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The bench models a PHY that rebuilds each frame from the MDC rising edges and compares it with a frame built from the requested fields. A wrong opcode, a swapped address field or a preamble one bit short shows up as a frame mismatch. The turnaround of a read is the sharpest corner. A master that keeps driving there collides with the PHY's zero, and one that samples one bit early or late returns the reply shifted by a position. The bench also writes a different command and new data in the middle of a transaction: a design that accepts them would corrupt the frame or overwrite the data register. It measures every MDC half period, in the slowest divider setting among others, so a divider that decodes its field wrongly or counts one too many is caught.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W   = 32;
  localparam int PHY_W   = 5;
  localparam int RA_W    = 5;
  localparam int DIV_W   = 2;
  localparam int RDATA_W = 16;

  // command register layout
  localparam int BUSY_BIT = 0;
  localparam int WR_BIT   = 1;
  localparam int RA_LSB   = WR_BIT + 1;
  localparam int PHY_LSB  = RA_LSB + RA_W;
  localparam int DIV_LSB  = PHY_LSB + PHY_W;
  localparam int CMD_TOP  = DIV_LSB + DIV_W - 1;

  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PHY_W-1:0] phy;
    logic [RA_W-1:0]  ra;
    logic             wr;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
#(
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             start,
  input  logic [DIV_W-1:0] sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int MAX_HALF_LOG2 = BASE_LOG2 - 1 + (2 ** DIV_W) - 1;
  localparam int CNT_W         = MAX_HALF_LOG2 + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic [DIV_W-1:0] sel_q;
  logic             edge_now;

  always_comb begin
    half_m1  = (CNT_W'(1) << (BASE_LOG2 - 1 + int'(sel_q))) - CNT_W'(1);
    edge_now = active && (cnt == half_m1);
    rise     = edge_now && !mdc;
    fall     = edge_now && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      sel_q <= '0;
    end else if (start) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      sel_q <= sel;
    end else if (active) begin
      if (edge_now) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  mdio_cmd_t          cmd,
  input  logic [RDATA_W-1:0] wdata,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [RDATA_W-1:0] rd_data
);
  localparam int TA_POS    = PRE_LEN + 4 + PHY_W + RA_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int FRAME_LEN = DATA_POS + RDATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx;
  logic                 is_wr;
  logic [RDATA_W-1:0]   rd_sh;
  logic                 last;

  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01, (cmd.wr ? 2'b01 : 2'b10),
             cmd.phy, cmd.ra, 2'b10,
             (cmd.wr ? wdata : {RDATA_W{1'b1}})};
    last  = (idx == IDX_W'(FRAME_LEN - 1));
    done  = fall && last;
  end

  assign rd_data = rd_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      idx     <= '0;
      is_wr   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_sh   <= '0;
    end else if (start) begin
      shreg   <= frame;
      idx     <= '0;
      is_wr   <= cmd.wr;
      mdio_o  <= frame[FRAME_LEN-1];
      mdio_oe <= 1'b1;
    end else begin
      if (rise && !is_wr && (int'(idx) >= DATA_POS))
        rd_sh <= {rd_sh[RDATA_W-2:0], mdio_i};
      if (fall) begin
        if (last) begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          idx     <= idx + IDX_W'(1);
          shreg   <= shreg << 1;
          mdio_o  <= shreg[FRAME_LEN-2];
          mdio_oe <= is_wr || ((int'(idx) + 1) < TA_POS);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               done,
  input  logic [RDATA_W-1:0] rd_data,
  output logic               start,
  output mdio_cmd_t          cmd_q,
  output logic [RDATA_W-1:0] data_q,
  output logic               busy,
  output logic [REG_W-1:0]   rdata
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[REG_W-1:CMD_TOP+1];

  assign start = wr_en && (addr == ADDR_CMD) && wdata[BUSY_BIT] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      busy   <= 1'b0;
      data_q <= '0;
    end else begin
      if (start) begin
        cmd_q <= mdio_cmd_t'(wdata[CMD_TOP:WR_BIT]);
        busy  <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
        if (!cmd_q.wr)
          data_q <= rd_data;
      end
      if (wr_en && (addr == ADDR_DATA) && !busy)
        data_q <= wdata[RDATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (addr == ADDR_CMD)
      rdata <= {{(REG_W-CMD_TOP-1){1'b0}}, cmd_q, busy};
    else
      rdata <= {{(REG_W-RDATA_W){1'b0}}, data_q};
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 4,
  parameter int PREAMBLE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic               start;
  logic               busy;
  logic               done;
  logic               rise;
  logic               fall;
  mdio_cmd_t          cmd_q;
  logic [RDATA_W-1:0] data_q;
  logic [RDATA_W-1:0] rd_data;

  mdio_regfile u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .done    (done),
    .rd_data (rd_data),
    .start   (start),
    .cmd_q   (cmd_q),
    .data_q  (data_q),
    .busy    (busy),
    .rdata   (reg_rdata)
  );

  mdio_clk_div #(.BASE_LOG2(BASE_DIV_LOG2)) u_div (
    .clk    (clk),
    .rst    (rst),
    .active (busy),
    .start  (start),
    .sel    (reg_wdata[CMD_TOP:DIV_LSB]),
    .mdc    (mdc),
    .rise   (rise),
    .fall   (fall)
  );

  mdio_shift_engine #(.PRE_LEN(PREAMBLE_LEN)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cmd     (mdio_cmd_t'(reg_wdata[CMD_TOP:WR_BIT])),
    .wdata   (data_q),
    .rise    (rise),
    .fall    (fall),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (done),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_sva.sv
module mdio_cmd_ctrl_sva
  import mdio_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        reg_addr,
  input logic                        reg_wr,
  input logic                        go_bit,
  input logic                        mdc,
  input logic                        mdio_o,
  input logic                        mdio_oe,
  input logic                        busy,
  input logic [$bits(mdio_cmd_t)-1:0] cmd_bits
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr && (reg_addr == ADDR_CMD) && go_bit) |=> busy);

  assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_drive_on_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

  assert_busy_cmd_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && (reg_addr == ADDR_CMD)) |=> $stable(cmd_bits));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .go_bit   (reg_wdata[0]),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .busy     (busy),
  .cmd_bits (cmd_q)
);

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_addr = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0;
  logic        phy_bit = 1'b1;
  wire         mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

  always #5 clk = ~clk;

  mdio_cmd_ctrl u_mdio_cmd_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  // PHY model state
  logic [63:0] cap, oe_cap;
  logic [15:0] resp;
  int  nbits = 0;
  bit  rd_flag = 0;
  time last_rise = 0;
  time exp_period = 160;
  int  period_bad = 0, high_bad = 0, drive_bad = 0, contention = 0;
  logic p_o = 1'b1, p_oe = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_i};
    oe_cap = {oe_cap[62:0], mdio_oe};
    if (nbits > 0 && ($time - last_rise) != exp_period) period_bad++;
    last_rise = $time;
    nbits++;
  end

  always @(negedge mdc) begin
    if (($time - last_rise) != exp_period / 2) high_bad++;
    if (nbits == 36) rd_flag = (cap[1:0] == 2'b10);
    if (rd_flag && nbits >= 47 && nbits <= 63) begin
      phy_oe  = 1'b1;
      phy_bit = (nbits == 47) ? 1'b0 : resp[63-nbits];
    end else begin
      phy_oe = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mdc && (mdio_o != p_o || mdio_oe != p_oe)) drive_bad++;
      if (mdio_oe && phy_oe) contention++;
    end
    p_o  = mdio_o;
    p_oe = mdio_oe;
  end

  function automatic logic [63:0] exp_frame(bit w, logic [4:0] phy, logic [4:0] ra,
                                            logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
  endfunction

  function automatic logic [63:0] exp_oe(bit w);
    return w ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
  endfunction

  function automatic logic [31:0] cmd_word(bit w, logic [4:0] phy, logic [4:0] ra,
                                           logic [1:0] div, bit go);
    return {18'b0, div, phy, ra, w, go};
  endfunction

  task automatic wr_reg(logic a, logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_reg(logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_txn(bit w, logic [4:0] phy, logic [4:0] ra, logic [1:0] div,
                         logic [15:0] data, logic [15:0] respv, bit disturb);
    logic [31:0] v;
    logic [31:0] cw;
    time t0, dur, nominal;
    string rq;
    nbits = 0; rd_flag = 0; period_bad = 0; high_bad = 0;
    drive_bad = 0; contention = 0;
    exp_period = (64'd16 << div) * 10;
    nominal = exp_period * 64;
    resp = respv;
    rq = w ? "R4" : "R5";
    wr_reg(1'b1, {16'h0, data});
    cw = cmd_word(w, phy, ra, div, 1'b1);
    wr_reg(1'b0, cw);
    t0 = $time;
    rd_reg(1'b0, v);
    chk(v[0] == 1'b1, "R2", "busy set after start", v[0], 1);
    chk(v[13:1] == cw[13:1], "R8", "command readback", v[13:1], cw[13:1]);
    if (disturb) begin
      wr_reg(1'b0, cmd_word(~w, ~phy, ~ra, div, 1'b1));
      wr_reg(1'b1, {16'h0, ~data});
      rd_reg(1'b0, v);
      chk(v[13:0] == cw[13:0], "R7", "command ignored while busy", v[13:0], cw[13:0]);
    end
    do begin
      rd_reg(1'b0, v);
    end while (v[0] && ($time - t0) < nominal + 2000);
    dur = $time - t0;
    chk(!v[0], "R2", "busy cleared", v[0], 0);
    chk(dur >= nominal - 20 && dur <= nominal + 60, "R2", "transaction length ns",
        dur, nominal);
    chk(nbits == 64, rq, "MDC rising edges", nbits, 64);
    chk(cap == exp_frame(w, phy, ra, w ? data : respv), rq, "frame bits",
        cap, exp_frame(w, phy, ra, w ? data : respv));
    chk(oe_cap == exp_oe(w), rq, "output enable per bit", oe_cap, exp_oe(w));
    chk(period_bad == 0, "R3", "MDC period mismatches", period_bad, 0);
    chk(high_bad == 0, "R3", "MDC high half mismatches", high_bad, 0);
    chk(!mdc, "R3", "MDC low after transaction", mdc, 0);
    chk(!mdio_oe, "R1", "output enable low when idle", mdio_oe, 0);
    chk(drive_bad == 0, "R6", "MDIO changes while MDC high", drive_bad, 0);
    chk(contention == 0, "R5", "master drove during PHY reply", contention, 0);
    rd_reg(1'b1, v);
    if (w)
      chk(v == {16'h0, data}, disturb ? "R7" : "R8", "data after write", v, data);
    else
      chk(v == {16'h0, respv}, disturb ? "R7" : "R5", "read data", v, respv);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1DC5_0A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_reg(1'b0, v);
    chk(v == 0, "R1", "command reg after reset", v, 0);
    rd_reg(1'b1, v);
    chk(v == 0, "R1", "data reg after reset", v, 0);
    chk(!mdc && !mdio_oe, "R1", "pins after reset", {mdc, mdio_oe}, 0);
    // R2 command without start bit does nothing
    nbits = 0;
    wr_reg(1'b0, cmd_word(1'b1, 5'd3, 5'd4, 2'd0, 1'b0));
    repeat (100) @(negedge clk);
    rd_reg(1'b0, v);
    chk(v[0] == 1'b0, "R2", "no start without bit 0", v[0], 0);
    chk(nbits == 0, "R2", "no MDC without start", nbits, 0);
    // directed corners
    run_txn(1'b1, 5'd31, 5'd0, 2'd3, 16'hA55A, 16'h0, 1'b0);
    run_txn(1'b0, 5'd1, 5'd31, 2'd0, 16'h1234, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd0, 5'd2, 2'd1, 16'h0, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'd9, 5'd17, 2'd0, 16'h8001, 16'h0, 1'b1);
    run_txn(1'b0, 5'd22, 5'd5, 2'd0, 16'h7777, 16'hC3A5, 1'b1);
    // random transactions
    for (int i = 0; i < 6; i++) begin
      run_txn(1'($urandom % 2), 5'($urandom), 5'($urandom), 2'($urandom % 2),
              16'($urandom), 16'($urandom), 1'($urandom % 2));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule